// File: doc/BRIEF.md
# Disc Controller Register Port

This block is the byte-wide register window of a disc data controller. A 4-bit pointer selects which register the next access reaches, and after most accesses the pointer steps forward by one. This lets a host walk through a group of registers with a run of back-to-back reads or writes. Reads and writes see two different register maps.

Some accesses have side effects beyond moving data:
- A write can start or abort a transfer, acknowledge a transfer-end interrupt, or reset the controller.
- Reading the last status byte clears the decoder flags.

The block holds the following state:
- the interface control register and the interface status flags;
- the transfer byte counter and the transfer address counter;
- the buffer write address and the block pointer;
- two control registers and the decode-mode status bytes.

Header bytes come from the decode block as two 32-bit sets, a current set and an alternate set. A control bit picks which set the host reads.

The transfer block and the decode block talk to this block through event inputs and flag outputs:
- `xfer_done_i` marks the end of a transfer.
- `dec_evt_i` marks a newly decoded block.

Both events update the interrupt flags and the interrupt line.

Top module: `disc_regport`

## Requirements
- R1: A read or a write at a pointer value from 1 to 14 advances the pointer by one on the next clock. An access at pointer 0 leaves the pointer at 0. An `idx_wr_i` cycle loads `idx_i` into the pointer; if it coincides with an access, the access uses the old pointer and the loaded value wins. When read and write strobes coincide, only the write takes effect.
- R2: A read at pointer 15 returns status byte 3 and wraps the pointer to 0.
- R3: A write at pointer 15 resets the controller and leaves the pointer at 0. After the reset, interface status reads 0xFF, interface control, both control registers and status bytes 0 and 2 are 0, and status byte 3 is 0x80. The write also clears the interrupt and pulses `xfer_abort_o` for one cycle. Counters, addresses and pointers are kept.
- R4: Write map:
  - byte counter: 2 (low), 3 (high);
  - address counter: 4, 5;
  - write address: 8, 9;
  - block pointer: 12, 13.

  Read map:
  - byte counter: 2, 3;
  - block pointer: 8, 9;
  - write address: 10, 11.

  The address counter appears on `dac_o`.
- R5: A read at pointer 0 returns 0xFF. Status byte 1 (read pointer 13) always reads 0.
- R6: Read pointers 4 to 7 return header bytes 0 to 3, where byte k is bits [8k+7:8k]. The bytes come from `hdr_alt_i` when bit 0 of control register 1 is 1, and from `hdr_cur_i` otherwise.
- R7: Writing control register 0 (write pointer 10) has two effects:
  - status byte 0 (read pointer 12) becomes data & 0x80;
  - status byte 2 (read pointer 14) becomes ctrl1 & 0x08 when data bit 4 is 1, and ctrl1 & 0x0C otherwise.
- R8: Writing control register 1 (write pointer 11) recomputes status byte 2 in the same way, using stored control register 0 bit 4 and the new data.
- R9: Writing interface control (write pointer 1) with data bit 1 clear sets interface status bits 3 (busy, active low) and 1 (data ready, active low). The same write pulses `xfer_abort_o`.
- R10: On an interface control write, `irq_o` is set when a newly enabled source is already pending, and cleared otherwise. The two sources are:
  - data bit 6 with status bit 6 at 0;
  - data bit 5 with status bit 5 at 0.
- R11: A trigger write (pointer 6) with interface control bit 1 set clears status bit 3, clears byte counter bits 15:12 and pulses `xfer_start_o`. With bit 1 clear, the trigger write has no effect.
- R12: A transfer-end acknowledge write (pointer 7) sets status bit 6 and clears byte counter bits 15:12.
- R13: Reading status byte 3 returns its value, then sets it to 0x80 and sets status bit 5. A `dec_evt_i` while control register 0 bit 7 is 1 clears status byte 3 and status bit 5, and raises `irq_o` if interface control bit 5 is 1. A `dec_evt_i` while bit 7 is 0 is ignored.
- R14: A `xfer_done_i` pulse has these effects:
  - loads the byte counter with 0xF000;
  - sets status bits 3 and 1 and clears status bit 6;
  - raises `irq_o` if interface control bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr_i | input | 1 | Load register pointer |
| idx_i | input | 4 | New register pointer value |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the current pointer (combinational) |
| dec_evt_i | input | 1 | Decode block produced a new block |
| xfer_done_i | input | 1 | Transfer block finished a transfer |
| hdr_cur_i | input | 32 | Current header set |
| hdr_alt_i | input | 32 | Alternate header set |
| idx_o | output | 4 | Current register pointer |
| ifstat_o | output | 8 | Interface status flags |
| ifctrl_o | output | 8 | Interface control register |
| ctrl0_o | output | 8 | Control register 0 |
| ctrl1_o | output | 8 | Control register 1 |
| dbc_o | output | 16 | Transfer byte counter |
| dac_o | output | 16 | Transfer address counter |
| wa_o | output | 16 | Buffer write address |
| pt_o | output | 16 | Block pointer |
| irq_o | output | 1 | Interrupt request |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| xfer_abort_o | output | 1 | One-cycle transfer abort pulse |

## Verification
The assertions check several properties on every cycle:
- the pointer step after ordinary accesses, the wrap at read pointer 15, and the return to 0 after the reset write;
- the 0xFF value at pointer 0;
- that a start pulse only appears with output enabled, and that start and abort never coincide.

The bench scenarios cover what needs a history of writes to observe:
- the split read and write maps;
- status byte 2 under both orders of control register writes;
- header set selection;
- the interrupt set and clear rules;
- the clear-on-read of status byte 3;
- the event-over-access ordering.

// File: rtl/disc_regport_pkg.sv
package disc_regport_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned IW = 4;
    localparam int unsigned CW = 2 * DW;
    localparam int unsigned HB = 4;

    // interface status / control bit positions
    localparam int unsigned S_XEND = 6;
    localparam int unsigned S_DEC  = 5;
    localparam int unsigned S_BUSY = 3;
    localparam int unsigned S_RDY  = 1;
    localparam int unsigned C_XEIE = 6;
    localparam int unsigned C_DCIE = 5;
    localparam int unsigned C_OEN  = 1;
    localparam int unsigned C0_DEN  = 7;
    localparam int unsigned C0_AUTO = 4;
    localparam int unsigned C1_ALT  = 0;

    // write map
    localparam logic [IW-1:0] W_IFC   = 4'h1;
    localparam logic [IW-1:0] W_CNTL  = 4'h2;
    localparam logic [IW-1:0] W_CNTH  = 4'h3;
    localparam logic [IW-1:0] W_ADRL  = 4'h4;
    localparam logic [IW-1:0] W_ADRH  = 4'h5;
    localparam logic [IW-1:0] W_TRIG  = 4'h6;
    localparam logic [IW-1:0] W_ACK   = 4'h7;
    localparam logic [IW-1:0] W_WAL   = 4'h8;
    localparam logic [IW-1:0] W_WAH   = 4'h9;
    localparam logic [IW-1:0] W_C0    = 4'hA;
    localparam logic [IW-1:0] W_C1    = 4'hB;
    localparam logic [IW-1:0] W_PTL   = 4'hC;
    localparam logic [IW-1:0] W_PTH   = 4'hD;
    localparam logic [IW-1:0] W_SRST  = 4'hF;

    // read map
    localparam logic [IW-1:0] R_IFS   = 4'h1;
    localparam logic [IW-1:0] R_CNTL  = 4'h2;
    localparam logic [IW-1:0] R_CNTH  = 4'h3;
    localparam logic [IW-1:0] R_HDR0  = 4'h4;
    localparam logic [IW-1:0] R_PTL   = 4'h8;
    localparam logic [IW-1:0] R_PTH   = 4'h9;
    localparam logic [IW-1:0] R_WAL   = 4'hA;
    localparam logic [IW-1:0] R_WAH   = 4'hB;
    localparam logic [IW-1:0] R_ST0   = 4'hC;
    localparam logic [IW-1:0] R_ST1   = 4'hD;
    localparam logic [IW-1:0] R_ST2   = 4'hE;
    localparam logic [IW-1:0] R_ST3   = 4'hF;

    localparam logic [DW-1:0] IFS_IDLE = 8'hFF;
    localparam logic [DW-1:0] ST3_IDLE = 8'h80;
    localparam logic [CW-1:0] CNT_DONE = 16'hF000;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [DW-1:0] ifstat;
        logic [DW-1:0] ifctrl;
        logic [CW-1:0] dbc;
        logic [CW-1:0] dac;
        logic [CW-1:0] wa;
        logic [CW-1:0] pt;
        logic [DW-1:0] ctrl0;
        logic [DW-1:0] ctrl1;
        logic [DW-1:0] stat0;
        logic [DW-1:0] stat2;
        logic [DW-1:0] stat3;
        logic          irq;
        logic          start;
        logic          abort;
    } regs_t;

    function automatic logic [DW-1:0] mode_stat(input logic auto_md, input logic [DW-1:0] c1);
        return auto_md ? (c1 & 8'h08) : (c1 & 8'h0C);
    endfunction

endpackage

// File: rtl/disc_regport_index.sv
module disc_regport_index
    import disc_regport_pkg::*;
(
    input  logic [IW-1:0] idx_q,
    input  logic          access,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    output logic [IW-1:0] idx_d
);
    // index 0 is a parking slot; all others step, 15 wraps to 0
    always_comb begin
        idx_d = idx_q;
        if (load)
            idx_d = load_val;
        else if (access && (idx_q != '0))
            idx_d = idx_q + 1'b1;
    end
endmodule

// File: rtl/disc_regport_rdmux.sv
module disc_regport_rdmux
    import disc_regport_pkg::*;
(
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    ifstat,
    input  logic [CW-1:0]    dbc,
    input  logic [CW-1:0]    wa,
    input  logic [CW-1:0]    pt,
    input  logic [DW-1:0]    stat0,
    input  logic [DW-1:0]    stat2,
    input  logic [DW-1:0]    stat3,
    input  logic             alt_sel,
    input  logic [HB*DW-1:0] hdr_cur,
    input  logic [HB*DW-1:0] hdr_alt,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] hsel [HB];

    for (genvar k = 0; k < HB; k++) begin : g_hdr
        assign hsel[k] = alt_sel ? hdr_alt[k*DW +: DW] : hdr_cur[k*DW +: DW];
    end

    always_comb begin
        rd_data = 8'hFF;
        unique case (idx)
            R_IFS:  rd_data = ifstat;
            R_CNTL: rd_data = dbc[DW-1:0];
            R_CNTH: rd_data = dbc[CW-1:DW];
            4'h4:   rd_data = hsel[0];
            4'h5:   rd_data = hsel[1];
            4'h6:   rd_data = hsel[2];
            4'h7:   rd_data = hsel[3];
            R_PTL:  rd_data = pt[DW-1:0];
            R_PTH:  rd_data = pt[CW-1:DW];
            R_WAL:  rd_data = wa[DW-1:0];
            R_WAH:  rd_data = wa[CW-1:DW];
            R_ST0:  rd_data = stat0;
            R_ST1:  rd_data = '0;
            R_ST2:  rd_data = stat2;
            R_ST3:  rd_data = stat3;
            default: rd_data = 8'hFF;
        endcase
    end
endmodule

// File: rtl/disc_regport.sv
module disc_regport
    import disc_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr_i,
    input  logic [IW-1:0]    idx_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic             dec_evt_i,
    input  logic             xfer_done_i,
    input  logic [HB*DW-1:0] hdr_cur_i,
    input  logic [HB*DW-1:0] hdr_alt_i,
    output logic [IW-1:0]    idx_o,
    output logic [DW-1:0]    ifstat_o,
    output logic [DW-1:0]    ifctrl_o,
    output logic [DW-1:0]    ctrl0_o,
    output logic [DW-1:0]    ctrl1_o,
    output logic [CW-1:0]    dbc_o,
    output logic [CW-1:0]    dac_o,
    output logic [CW-1:0]    wa_o,
    output logic [CW-1:0]    pt_o,
    output logic             irq_o,
    output logic             xfer_start_o,
    output logic             xfer_abort_o
);
    regs_t         q, d;
    logic [IW-1:0] idx_nxt;
    logic          rd_go;

    assign rd_go = rd_en_i && !wr_en_i;

    disc_regport_index u_index (
        .idx_q    (q.idx),
        .access   (rd_en_i || wr_en_i),
        .load     (idx_wr_i),
        .load_val (idx_i),
        .idx_d    (idx_nxt)
    );

    disc_regport_rdmux u_rdmux (
        .idx     (q.idx),
        .ifstat  (q.ifstat),
        .dbc     (q.dbc),
        .wa      (q.wa),
        .pt      (q.pt),
        .stat0   (q.stat0),
        .stat2   (q.stat2),
        .stat3   (q.stat3),
        .alt_sel (q.ctrl1[C1_ALT]),
        .hdr_cur (hdr_cur_i),
        .hdr_alt (hdr_alt_i),
        .rd_data (rd_data_o)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        d.idx   = idx_nxt;

        if (wr_en_i) begin
            unique case (q.idx)
                W_IFC: begin
                    d.irq = (wr_data_i[C_XEIE] && !q.ifstat[S_XEND]) ||
                            (wr_data_i[C_DCIE] && !q.ifstat[S_DEC]);
                    if (!wr_data_i[C_OEN]) begin
                        d.ifstat[S_BUSY] = 1'b1;
                        d.ifstat[S_RDY]  = 1'b1;
                        d.abort          = 1'b1;
                    end
                    d.ifctrl = wr_data_i;
                end
                W_CNTL: d.dbc[DW-1:0]  = wr_data_i;
                W_CNTH: d.dbc[CW-1:DW] = wr_data_i;
                W_ADRL: d.dac[DW-1:0]  = wr_data_i;
                W_ADRH: d.dac[CW-1:DW] = wr_data_i;
                W_TRIG: begin
                    if (q.ifctrl[C_OEN]) begin
                        d.ifstat[S_BUSY]   = 1'b0;
                        d.dbc[CW-1:CW-4]   = '0;
                        d.start            = 1'b1;
                    end
                end
                W_ACK: begin
                    d.ifstat[S_XEND] = 1'b1;
                    d.dbc[CW-1:CW-4] = '0;
                end
                W_WAL:  d.wa[DW-1:0]  = wr_data_i;
                W_WAH:  d.wa[CW-1:DW] = wr_data_i;
                W_C0: begin
                    d.stat0 = wr_data_i & 8'h80;
                    d.stat2 = mode_stat(wr_data_i[C0_AUTO], q.ctrl1);
                    d.ctrl0 = wr_data_i;
                end
                W_C1: begin
                    d.stat2 = mode_stat(q.ctrl0[C0_AUTO], wr_data_i);
                    d.ctrl1 = wr_data_i;
                end
                W_PTL:  d.pt[DW-1:0]  = wr_data_i;
                W_PTH:  d.pt[CW-1:DW] = wr_data_i;
                W_SRST: begin
                    d.ifstat = IFS_IDLE;
                    d.ifctrl = '0;
                    d.ctrl0  = '0;
                    d.ctrl1  = '0;
                    d.stat0  = '0;
                    d.stat2  = '0;
                    d.stat3  = ST3_IDLE;
                    d.irq    = 1'b0;
                    d.abort  = 1'b1;
                end
                default: ;
            endcase
        end else if (rd_go && (q.idx == R_ST3)) begin
            d.stat3         = ST3_IDLE;
            d.ifstat[S_DEC] = 1'b1;
        end

        // events from neighbour blocks override the register access
        if (dec_evt_i && q.ctrl0[C0_DEN]) begin
            d.stat3         = '0;
            d.ifstat[S_DEC] = 1'b0;
            if (q.ifctrl[C_DCIE])
                d.irq = 1'b1;
        end
        if (xfer_done_i) begin
            d.dbc             = CNT_DONE;
            d.ifstat[S_BUSY]  = 1'b1;
            d.ifstat[S_RDY]   = 1'b1;
            d.ifstat[S_XEND]  = 1'b0;
            if (q.ifctrl[C_XEIE])
                d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ifstat <= IFS_IDLE;
            q.stat3  <= ST3_IDLE;
        end else begin
            q <= d;
        end
    end

    assign idx_o        = q.idx;
    assign ifstat_o     = q.ifstat;
    assign ifctrl_o     = q.ifctrl;
    assign ctrl0_o      = q.ctrl0;
    assign ctrl1_o      = q.ctrl1;
    assign dbc_o        = q.dbc;
    assign dac_o        = q.dac;
    assign wa_o         = q.wa;
    assign pt_o         = q.pt;
    assign irq_o        = q.irq;
    assign xfer_start_o = q.start;
    assign xfer_abort_o = q.abort;
endmodule

// File: rtl/disc_regport_chk.sv
module disc_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en_i,
    input logic       wr_en_i,
    input logic       idx_wr_i,
    input logic [3:0] idx_o,
    input logic [7:0] rd_data_o,
    input logic       outen,
    input logic       irq_o,
    input logic       xfer_start_o,
    input logic       xfer_abort_o
);
    // R1
    a_r1_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en_i || wr_en_i) && !idx_wr_i && (idx_o != 4'h0) && (idx_o != 4'hF))
        |=> (idx_o == 4'($past(idx_o) + 4'd1)));

    // R2
    a_r2_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && !idx_wr_i && (idx_o == 4'hF)) |=> (idx_o == 4'h0));

    // R3
    a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !idx_wr_i && (idx_o == 4'hF)) |=> ((idx_o == 4'h0) && xfer_abort_o && !irq_o));

    // R5
    a_r5_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o == 4'h0) |-> (rd_data_o == 8'hFF));

    // R11
    a_r11_start_needs_outen: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> outen);

    // R9 / R11: start and abort come from exclusive writes
    a_r9_no_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_start_o && xfer_abort_o));
endmodule

bind disc_regport disc_regport_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en_i      (rd_en_i),
    .wr_en_i      (wr_en_i),
    .idx_wr_i     (idx_wr_i),
    .idx_o        (idx_o),
    .rd_data_o    (rd_data_o),
    .outen        (ifctrl_o[1]),
    .irq_o        (irq_o),
    .xfer_start_o (xfer_start_o),
    .xfer_abort_o (xfer_abort_o)
);

// File: tb/disc_regport_tb.sv
module disc_regport_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic [3:0]  idx_in = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        dec_evt = 1'b0;
    logic        xfer_done = 1'b0;
    logic [31:0] hdr_cur = 32'h44332211;
    logic [31:0] hdr_alt = 32'hDDCCBBAA;
    logic [3:0]  idx_o;
    logic [7:0]  ifstat_o, ifctrl_o, ctrl0_o, ctrl1_o;
    logic [15:0] dbc_o, dac_o, wa_o, pt_o;
    logic        irq_o, xfer_start_o, xfer_abort_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    disc_regport dut_i (
        .clk(clk), .rst_n(rst_n), .idx_wr_i(idx_wr), .idx_i(idx_in),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .dec_evt_i(dec_evt), .xfer_done_i(xfer_done),
        .hdr_cur_i(hdr_cur), .hdr_alt_i(hdr_alt),
        .idx_o(idx_o), .ifstat_o(ifstat_o), .ifctrl_o(ifctrl_o),
        .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .dbc_o(dbc_o), .dac_o(dac_o),
        .wa_o(wa_o), .pt_o(pt_o), .irq_o(irq_o),
        .xfer_start_o(xfer_start_o), .xfer_abort_o(xfer_abort_o)
    );

    function automatic logic [7:0] exp_stat2(input logic [7:0] c0, input logic [7:0] c1);
        return c0[4] ? (c1 & 8'h08) : (c1 & 8'h0C);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [3:0] i);
        idx_wr = 1'b1; idx_in = i;
        @(posedge clk); #1;
        idx_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] dat);
        wr_en = 1'b1; wr_data = dat;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] dat);
        rd_en = 1'b1; #1;
        dat = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_dec();
        dec_evt = 1'b1; @(posedge clk); #1; dec_evt = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1; @(posedge clk); #1; xfer_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // reset state
        chk("R3 reset idx", idx_o, 4'h0);
        chk("R10 reset irq", irq_o, 1'b0);
        // R5 index 0 reads FF and does not move
        rd(v); chk("R5 idx0 data", v, 8'hFF); chk("R1 idx0 parked", idx_o, 4'h0);
        set_idx(4'h1); rd(v); chk("R3 reset ifstat", v, 8'hFF);

        // R1/R4 byte counter run
        set_idx(4'h2); wr(8'h34); wr(8'hF2);
        chk("R1 step after two writes", idx_o, 4'h4);
        set_idx(4'h2); rd(v); chk("R4 dbc lo", v, 8'h34); rd(v); chk("R4 dbc hi", v, 8'hF2);
        // R4 pointer, write address, address counter
        set_idx(4'hC); wr(8'h11); wr(8'h22);
        set_idx(4'h8); rd(v); chk("R4 pt lo", v, 8'h11); rd(v); chk("R4 pt hi", v, 8'h22);
        set_idx(4'h8); wr(8'h55); wr(8'h66);
        set_idx(4'hA); rd(v); chk("R4 wa lo", v, 8'h55); rd(v); chk("R4 wa hi", v, 8'h66);
        set_idx(4'h4); wr(8'h88); wr(8'h77);
        chk("R4 dac", dac_o, 16'h7788);

        // R9 ifctrl write with output disabled
        set_idx(4'h1); wr(8'h00);
        chk("R9 abort pulse", xfer_abort_o, 1'b1);
        chk("R10 irq clear", irq_o, 1'b0);
        // R11 trigger without output enable
        set_idx(4'h6); wr(8'h00);
        chk("R11 no start", xfer_start_o, 1'b0);
        set_idx(4'h1); rd(v); chk("R11 ifstat unchanged", v, 8'hFF);
        // R11 trigger with output enable
        set_idx(4'h1); wr(8'h62);
        chk("R10 nothing pending", irq_o, 1'b0);
        set_idx(4'h6); wr(8'h00);
        chk("R11 start pulse", xfer_start_o, 1'b1);
        set_idx(4'h1); rd(v); chk("R11 busy", v, 8'hF7);
        rd(v); rd(v); chk("R11 dbc hi trimmed", v, 8'h02);

        // R14 transfer done
        pulse_done();
        chk("R14 irq", irq_o, 1'b1);
        set_idx(4'h1); rd(v); chk("R14 ifstat", v, 8'hBF);
        chk("R14 dbc", dbc_o, 16'hF000);
        // R12 acknowledge
        set_idx(4'h7); wr(8'h00);
        set_idx(4'h1); rd(v); chk("R12 ifstat", v, 8'hFF);
        chk("R12 dbc hi", dbc_o[15:8], 8'h00);
        // R10 re-enable with nothing pending clears irq
        set_idx(4'h1); wr(8'h62); chk("R10 irq dropped", irq_o, 1'b0);
        // R10 pending source then enable raises irq
        pulse_done();
        set_idx(4'h1); wr(8'h02); chk("R10 irq off when disabled", irq_o, 1'b0);
        set_idx(4'h1); wr(8'h42); chk("R10 irq raised on enable", irq_o, 1'b1);
        set_idx(4'h7); wr(8'h00);
        set_idx(4'h1); wr(8'h62); chk("R10 irq cleared", irq_o, 1'b0);

        // R13 decoder events
        pulse_dec();
        chk("R13 ignored irq", irq_o, 1'b0);
        set_idx(4'hF); rd(v); chk("R13 ignored st3", v, 8'h80);
        chk("R2 wrap", idx_o, 4'h0);
        set_idx(4'hA); wr(8'h80);
        pulse_dec();
        chk("R13 dec irq", irq_o, 1'b1);
        set_idx(4'h1); rd(v); chk("R13 dec pending", v, 8'hDF);
        set_idx(4'hF); rd(v); chk("R13 st3 value", v, 8'h00);
        chk("R2 wrap after st3", idx_o, 4'h0);
        set_idx(4'hF); rd(v); chk("R13 st3 restored", v, 8'h80);
        set_idx(4'h1); rd(v); chk("R13 dec cleared", v, 8'hFF);

        // R7/R8 random control writes, both orders
        for (int n = 0; n < 24; n++) begin
            logic [7:0] c0, c1;
            c0 = 8'($urandom); c1 = 8'($urandom);
            if (n % 2 == 0) begin
                set_idx(4'hA); wr(c0); wr(c1);
            end else begin
                set_idx(4'hB); wr(c1); set_idx(4'hA); wr(c0);
            end
            set_idx(4'hC);
            rd(v); chk("R7 stat0", v, c0 & 8'h80);
            rd(v); chk("R5 stat1", v, 8'h00);
            rd(v); chk(n % 2 == 0 ? "R8 stat2" : "R7 stat2", v, exp_stat2(c0, c1));
        end

        // R6 header selection
        for (int n = 0; n < 12; n++) begin
            logic [7:0] c1;
            hdr_cur = $urandom; hdr_alt = $urandom;
            c1 = 8'($urandom);
            set_idx(4'hB); wr(c1);
            set_idx(4'h4);
            for (int k = 0; k < 4; k++) begin
                rd(v);
                chk("R6 header", v, c1[0] ? hdr_alt[k*8 +: 8] : hdr_cur[k*8 +: 8]);
            end
        end

        // R1 write beats read in the same cycle
        set_idx(4'h2);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h5A;
        @(posedge clk); #1; wr_en = 1'b0; rd_en = 1'b0;
        chk("R1 dual access step", idx_o, 4'h3);
        set_idx(4'h2); rd(v); chk("R1 write wins", v, 8'h5A);
        // R1 pointer load with a coinciding write
        set_idx(4'h8);
        idx_wr = 1'b1; idx_in = 4'h5; wr_en = 1'b1; wr_data = 8'h99;
        @(posedge clk); #1; idx_wr = 1'b0; wr_en = 1'b0;
        chk("R1 load wins", idx_o, 4'h5);
        chk("R1 access at old idx", wa_o[7:0], 8'h99);

        // R3 soft reset
        set_idx(4'hB); wr(8'h01);
        set_idx(4'hA); wr(8'h90);
        set_idx(4'h1); wr(8'h62);
        set_idx(4'hF); wr(8'h00);
        chk("R3 idx", idx_o, 4'h0);
        chk("R3 abort", xfer_abort_o, 1'b1);
        chk("R3 ifctrl", ifctrl_o, 8'h00);
        chk("R3 ctrl0", ctrl0_o, 8'h00);
        chk("R3 ctrl1", ctrl1_o, 8'h00);
        chk("R3 wa kept", wa_o[7:0], 8'h99);
        set_idx(4'h1); rd(v); chk("R3 ifstat", v, 8'hFF);
        set_idx(4'hC);
        rd(v); chk("R3 stat0", v, 8'h00);
        rd(v); rd(v); chk("R3 stat2", v, 8'h00);
        rd(v); chk("R3 stat3", v, 8'h80);
        set_idx(4'h4); rd(v); chk("R3 header current", v, hdr_cur[7:0]);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule